// File: doc/BRIEF.md
# Four-Lane Link Self-Test Sequencer

This block controls a built-in self-test for a serial link with four lanes. Software reaches it through a small 16-bit register port. One control word picks the test pattern family and the symbol width. The same word also drives a three-step handshake: the unit is enabled first, then started, and later stopped. While a run is active, saturating counters record the frames sent, plus the frames received and the errors seen on each lane. Per-lane pulse inputs from a pattern stub feed these counters. Once a stop is requested, the counters freeze and keep their values for software to read.

The sequencer has four states. `ST_IDLE` means disabled. `ST_ARMED` means enabled and waiting for a start. `ST_RUN` means counting. `ST_DRAIN` means a stop is being flushed. The transitions are:

- enable: `ST_IDLE`→`ST_ARMED`
- start: `ST_ARMED`→`ST_RUN`
- stop: `ST_RUN`→`ST_DRAIN`
- flushed: `ST_DRAIN`→`ST_ARMED`, after two cycles
- disable: any state→`ST_IDLE`, whenever a control write has the enable bit at 0

Top module: `lane_bist_ctrl`

## Requirements
- R1: After reset, the control word, every counter and `test_active` read 0.
- R2: Control word (offset 0) layout:
  - bits 11:10 hold the pattern type: 0 deterministic, 1 CRPAT, 2 CJPAT, 3 pseudo-random.
  - bit 12 selects 10-bit symbols when 1 and 8-bit symbols when 0.
  - bit 13 is enable, bit 14 is stop and bit 15 is start.
  - bits 9:0 read 0.
- R3: A control write with bit 13 at 0 returns the unit to idle. Enable, start and stop then read 0, and no further pulses are counted.
- R4: A start write is ignored unless enable already reads 1 in `ST_ARMED`. A write that sets enable and start together from idle only enables the unit.
- R5: Start reads 1 from the accepted start write until a write with the stop bit set arrives. That write clears start.
- R6: After a stop write during a run, the stop bit reads 1 for exactly two cycles and then clears itself. Enable stays 1.
- R7: All counters are zeroed on the clock edge that accepts a start.
- R8: While running, the counters count pulses as follows:
  - offset 1 counts `tx_frame_pulse`.
  - offsets 2..5 count `rx_frame_pulse` for lanes 0..3.
  - offsets 6..9 count `rx_err_pulse` for lanes 0..3.
  - a pulse adds one per cycle. Counting stops from the cycle that presents the stop write onward.
- R9: Counters saturate at 0xFFFF and never wrap.
- R10: Reads of offsets 10..15 return 0. `reg_rdata` is 0 whenever `reg_rd` is low.
- R11: Pattern type and symbol width are locked during `ST_RUN` and `ST_DRAIN`. Control writes in those states leave them unchanged.
- R12: `pat_type` and `sym10` mirror control bits 11:10 and 12. `test_active` is 1 exactly in `ST_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; read data is combinational |
| reg_rdata | output | 16 | Read data |
| tx_frame_pulse | input | 1 | One pulse per transmitted test frame |
| rx_frame_pulse | input | 4 | Per-lane received-frame pulses |
| rx_err_pulse | input | 4 | Per-lane error pulses |
| pat_type | output | 2 | Selected pattern family |
| sym10 | output | 1 | 10-bit symbol mode |
| test_active | output | 1 | High while the run is counting |

## Verification
A register write takes effect on the clock edge after the write strobe. The bench therefore reads back at the following falling edge, and reads are combinational within a single low phase. Pulse inputs are held for exactly one rising edge each, so every pulse appears in a counter one edge later.

The stop bit is sampled at the first, second and third falling edges after the stop write, giving an expected 1, 1, 0. The pulses that coincide with the stop write are confirmed to leave the counters unchanged. Expected per-lane counts are tallied arithmetically from the pulse pattern the bench drives.

// File: rtl/bist_pkg.sv
`timescale 1ns/1ps
package bist_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } bist_state_e;

    // control word bit positions (software decodes these)
    localparam int CW_TYPE_LO = 10;
    localparam int CW_SYM10   = 12;
    localparam int CW_ENABLE  = 13;
    localparam int CW_STOP    = 14;
    localparam int CW_START   = 15;
endpackage

// File: rtl/bist_sat_cnt.sv
`timescale 1ns/1ps
module bist_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         pulse,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en && pulse && cnt != TOP)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bist_seq_fsm.sv
`timescale 1ns/1ps
module bist_seq_fsm
    import bist_pkg::*;
#(
    parameter int DRAIN_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctrl,
    input  logic        w_enable,
    input  logic        w_start,
    input  logic        w_stop,
    output bist_state_e st,
    output logic        cnt_clr,
    output logic        cnt_en
);
    localparam int DW = (DRAIN_CYC > 1) ? $clog2(DRAIN_CYC) : 1;
    localparam logic [DW-1:0] DLAST = DW'(DRAIN_CYC - 1);

    bist_state_e st_nx;
    logic [DW-1:0] dcnt;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (wr_ctrl && w_enable) st_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (wr_ctrl && !w_enable)    st_nx = ST_IDLE;
                else if (wr_ctrl && w_start) st_nx = ST_RUN;
            end
            ST_RUN: begin
                if (wr_ctrl && !w_enable)   st_nx = ST_IDLE;
                else if (wr_ctrl && w_stop) st_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (wr_ctrl && !w_enable) st_nx = ST_IDLE;
                else if (dcnt == DLAST)   st_nx = ST_ARMED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            dcnt <= '0;
        end else begin
            st   <= st_nx;
            dcnt <= (st == ST_DRAIN && st_nx == ST_DRAIN) ? dcnt + 1'b1 : '0;
        end
    end

    always_comb begin
        cnt_clr = (st == ST_ARMED) && wr_ctrl && w_enable && w_start;
        cnt_en  = (st == ST_RUN) && !(wr_ctrl && (!w_enable || w_stop));
    end
endmodule

// File: rtl/lane_bist_ctrl.sv
`timescale 1ns/1ps
module lane_bist_ctrl
    import bist_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 4,
    parameter int DRAIN_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [15:0]       reg_rdata,
    input  logic              tx_frame_pulse,
    input  logic [LANES-1:0]  rx_frame_pulse,
    input  logic [LANES-1:0]  rx_err_pulse,
    output logic [1:0]        pat_type,
    output logic              sym10,
    output logic              test_active
);
    localparam int OFS_TX  = 1;
    localparam int RXF_BASE = 2;
    localparam int RXE_BASE = RXF_BASE + LANES;

    bist_state_e st;
    logic        cnt_clr, cnt_en, wr_ctrl;
    logic [1:0]  pat_q;
    logic        sym_q;
    logic [CNT_W-1:0] tx_cnt;
    logic [CNT_W-1:0] rxf_cnt [LANES];
    logic [CNT_W-1:0] rxe_cnt [LANES];
    logic        unused_wbits;

    assign unused_wbits = ^reg_wdata[CW_TYPE_LO-1:0];
    assign wr_ctrl = reg_wr && (reg_addr == '0);

    bist_seq_fsm #(.DRAIN_CYC(DRAIN_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .w_enable(reg_wdata[CW_ENABLE]),
        .w_start (reg_wdata[CW_START]),
        .w_stop  (reg_wdata[CW_STOP]),
        .st      (st),
        .cnt_clr (cnt_clr),
        .cnt_en  (cnt_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= '0;
            sym_q <= 1'b0;
        end else if (wr_ctrl && st != ST_RUN && st != ST_DRAIN) begin
            pat_q <= reg_wdata[CW_TYPE_LO +: 2];
            sym_q <= reg_wdata[CW_SYM10];
        end
    end

    bist_sat_cnt #(.W(CNT_W)) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
        .pulse(tx_frame_pulse), .cnt(tx_cnt)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bist_sat_cnt #(.W(CNT_W)) u_rxf (
            .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
            .pulse(rx_frame_pulse[l]), .cnt(rxf_cnt[l])
        );
        bist_sat_cnt #(.W(CNT_W)) u_rxe (
            .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
            .pulse(rx_err_pulse[l]), .cnt(rxe_cnt[l])
        );
    end

    always_comb begin
        logic [15:0] ctrl_word;
        logic [15:0] mux;
        ctrl_word = '0;
        ctrl_word[CW_TYPE_LO +: 2] = pat_q;
        ctrl_word[CW_SYM10]  = sym_q;
        ctrl_word[CW_ENABLE] = (st != ST_IDLE);
        ctrl_word[CW_STOP]   = (st == ST_DRAIN);
        ctrl_word[CW_START]  = (st == ST_RUN);
        mux = '0;
        if (reg_addr == '0)
            mux = ctrl_word;
        else if (reg_addr == ADDR_W'(OFS_TX))
            mux = 16'(tx_cnt);
        for (int l = 0; l < LANES; l++) begin
            if (reg_addr == ADDR_W'(RXF_BASE + l)) mux = 16'(rxf_cnt[l]);
            if (reg_addr == ADDR_W'(RXE_BASE + l)) mux = 16'(rxe_cnt[l]);
        end
        reg_rdata = reg_rd ? mux : 16'h0000;
    end

    assign pat_type    = pat_q;
    assign sym10       = sym_q;
    assign test_active = (st == ST_RUN);
endmodule

// File: rtl/lane_bist_ctrl_chk.sv
`timescale 1ns/1ps
module lane_bist_ctrl_chk
    import bist_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input bist_state_e      st,
    input logic             cnt_en,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [1:0]       pat_type
);
    p_drain_two_cycles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN && $past(st) == ST_DRAIN) |=> (st != ST_DRAIN));

    p_start_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && $past(st) != ST_RUN) |-> ($past(st) == ST_ARMED));

    p_zero_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_clr) |-> (tx_cnt == '0));

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_en) && !$past(cnt_clr)) |-> $stable(tx_cnt));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_cnt) == {CNT_W{1'b1}} && !$past(cnt_clr)) |-> (tx_cnt == {CNT_W{1'b1}}));

    p_fields_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_RUN && st == ST_RUN) |-> $stable(pat_type));
endmodule

bind lane_bist_ctrl lane_bist_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .cnt_en  (cnt_en),
    .cnt_clr (cnt_clr),
    .tx_cnt  (tx_cnt),
    .pat_type(pat_type)
);

// File: tb/lane_bist_ctrl_bench.sv
`timescale 1ns/1ps
module lane_bist_ctrl_bench;
    localparam logic [15:0] EN  = 16'h2000;
    localparam logic [15:0] STP = 16'h4000;
    localparam logic [15:0] STR = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic        tx_frame_pulse = 1'b0;
    logic [3:0]  rx_frame_pulse = '0, rx_err_pulse = '0;
    logic [1:0]  pat_type;
    logic        sym10, test_active;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    lane_bist_ctrl u_lane_bist_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .tx_frame_pulse(tx_frame_pulse), .rx_frame_pulse(rx_frame_pulse),
        .rx_err_pulse(rx_err_pulse), .pat_type(pat_type), .sym10(sym10),
        .test_active(test_active)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [15:0] d);
        @(negedge clk);
        reg_addr = 4'd0; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        reg_addr = a[3:0]; reg_rd = 1'b1;
        #1 v = reg_rdata;
        reg_rd = 1'b0;
        #1;
    endtask

    initial begin
        #3000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v, t0;
        int exp_tx;
        int exp_rxf [4];
        int exp_rxe [4];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); check("R1 ctrl", v, 0);
        for (int a = 1; a < 10; a++) begin rd(a, v); check("R1 counter", v, 0); end
        check("R1 test_active", test_active, 0);

        // R2/R12 sweep of pattern type and symbol width
        for (int t = 0; t < 4; t++) begin
            for (int s = 0; s < 2; s++) begin
                wr_ctrl(EN | 16'(s << 12) | 16'(t << 10));
                rd(0, v); check("R2 ctrl readback", v, 'h2000 | (s << 12) | (t << 10));
                check("R12 pat_type", pat_type, t);
                check("R12 sym10", sym10, s);
            end
        end

        // R3 disable from armed
        wr_ctrl(16'h0000);
        rd(0, v); check("R3 disabled ctrl", v, 0);

        // R4 start with enable from idle only enables
        wr_ctrl(STR | EN | 16'h0400);
        rd(0, v); check("R4 start ignored", v, 'h2400);
        check("R4 not active", test_active, 0);
        for (int i = 0; i < 5; i++) begin @(negedge clk); tx_frame_pulse = 1'b1; end
        @(negedge clk); tx_frame_pulse = 1'b0;
        rd(1, v); check("R4 no counting when armed", v, 0);

        // R5/R7 start accepted
        wr_ctrl(STR | EN | 16'h0400);
        rd(0, v); check("R5 start set", v, 'ha400);
        check("R12 active", test_active, 1);
        rd(1, v); check("R7 tx zero", v, 0);

        // R8/R10 per-lane pulse sweep
        exp_tx = 0;
        for (int l = 0; l < 4; l++) begin exp_rxf[l] = 0; exp_rxe[l] = 0; end
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            tx_frame_pulse = (i % 3) != 2;
            if ((i % 3) != 2) exp_tx++;
            for (int l = 0; l < 4; l++) begin
                rx_frame_pulse[l] = (i % (l + 1)) == 0;
                rx_err_pulse[l]   = (i % (l + 2)) == 0;
            end
        end
        @(negedge clk);
        tx_frame_pulse = 1'b0; rx_frame_pulse = '0; rx_err_pulse = '0;
        for (int l = 0; l < 4; l++) begin
            exp_rxf[l] = (24 + l) / (l + 1);
            exp_rxe[l] = (24 + l + 1) / (l + 2);
        end
        rd(1, v); check("R8 tx count", v, exp_tx);
        for (int l = 0; l < 4; l++) begin
            rd(2 + l, v); check("R8 rx frames", v, exp_rxf[l]);
            rd(6 + l, v); check("R8 rx errors", v, exp_rxe[l]);
        end

        // R11 fields locked during run
        wr_ctrl(STR | EN | 16'h1c00);
        rd(0, v); check("R11 fields locked", v, 'ha400);
        check("R11 pat_type", pat_type, 1);

        // R6/R8 stop handshake with pulses held
        rd(1, t0);
        @(negedge clk);
        tx_frame_pulse = 1'b1; reg_addr = 4'd0; reg_wdata = STP | EN | 16'h0400; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(0, v); check("R6 stop cycle 1", v, 'h6400);
        @(negedge clk);
        rd(0, v); check("R6 stop cycle 2", v, 'h6400);
        @(negedge clk);
        rd(0, v); check("R6 stop cleared", v, 'h2400);
        tx_frame_pulse = 1'b0;
        rd(1, v); check("R8 frozen at stop", v, t0);

        // R10 unmapped and strobe-low reads
        for (int a = 10; a < 16; a++) begin rd(a, v); check("R10 unmapped", v, 0); end
        reg_addr = 4'd1; #1 check("R10 no strobe", reg_rdata, 0);

        // R7 restart zeroes counters
        wr_ctrl(STR | EN | 16'h0400);
        for (int a = 1; a < 10; a++) begin rd(a, v); check("R7 zero on restart", v, 0); end

        // R3 disable during run freezes counting
        for (int i = 0; i < 3; i++) begin @(negedge clk); tx_frame_pulse = 1'b1; end
        @(negedge clk); tx_frame_pulse = 1'b0;
        wr_ctrl(16'h0000);
        rd(0, v); check("R3 disabled from run", v, 'h0400);
        for (int i = 0; i < 4; i++) begin @(negedge clk); tx_frame_pulse = 1'b1; end
        @(negedge clk); tx_frame_pulse = 1'b0;
        rd(1, v); check("R3 no count after disable", v, 3);

        // R9 saturation
        wr_ctrl(EN);
        wr_ctrl(STR | EN);
        @(negedge clk);
        tx_frame_pulse = 1'b1; rx_err_pulse[3] = 1'b1;
        repeat (65540) @(negedge clk);
        tx_frame_pulse = 1'b0; rx_err_pulse[3] = 1'b0;
        rd(1, v); check("R9 tx saturated", v, 'hffff);
        rd(9, v); check("R9 err saturated", v, 'hffff);
        wr_ctrl(STP | EN);
        repeat (3) @(negedge clk);
        rd(1, v); check("R9 held after stop", v, 'hffff);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule